// File: doc/BRIEF.md
# Powered-Port Overload and Disconnect Supervisor

This block watches a port that has already been granted power. Three comparator flags come in: the load current is above the overcurrent trip, the load current sits at the hard limit of the pass switch, and the load current is below the hold threshold. The block integrates them over a 1 ms tick into counters that rise toward a timeout and fall back toward zero at a different rate. Short excursions are therefore remembered rather than forgotten, and a run of them that adds up still trips.

The overcurrent timer rises 16 times faster than it falls. The disconnect timer falls 10 times faster than it rises. A third timer, for class 4 loads only, counts consecutive ticks at the hard limit. Any timer that reaches its timeout sends a one-cycle pulse to the port sequencer. When the sequencer drops the powered flag, all timers clear. The trip threshold itself is computed elsewhere, so only the comparison results reach this block.

Top module: `port_fault_timers`

## Requirements
- R1: While reset is asserted, and after release until a timeout is reached, `ovl_fault` and `unplug_evt` are 0 and all timers are zero.
- R2: The overcurrent timer is held in sixteenths of a millisecond. On each tick with `port_on`=1 and `over_trip`=1 it gains 16, saturating at 960 (60 ms). With `over_trip` held from zero, `ovl_fault` pulses on the 60th tick and not before.
- R3: On a powered tick with `over_trip`=0, the overcurrent timer loses 1 (one sixteenth of the rise rate) and saturates at zero. The fault fires on the tick where the timer first reaches 960.
- R4: A hard-limit timer adds 1 on each powered tick with `big_load`=1 and `at_limit`=1, saturating at 15. It returns to zero on any powered tick where either flag is 0. Reaching 15 pulses `ovl_fault`. With `big_load`=0, `at_limit` has no effect.
- R5: The disconnect timer adds 1 ms on each powered tick with `under_hold`=1, saturating at 350. The tick on which it first reaches 350 pulses `unplug_evt`.
- R6: On a powered tick with `under_hold`=0, the disconnect timer loses 10 ms and saturates at zero.
- R7: Any clock with `port_on`=0 clears all three timers, and no pulse is produced while unpowered.
- R8: Each output is high for exactly one clock, in the clock after the tick that caused it. Flags that change on clocks without `tick_1ms` have no effect.
- R9: When an overcurrent timeout and a disconnect timeout occur on the same tick, only `ovl_fault` pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_1ms | input | 1 | One-clock strobe every millisecond |
| port_on | input | 1 | Port is in the powered state |
| big_load | input | 1 | Granted class is 4 |
| over_trip | input | 1 | Current above overcurrent trip |
| at_limit | input | 1 | Current at hard limit |
| under_hold | input | 1 | Current below hold threshold |
| ovl_fault | output | 1 | Overcurrent shutdown pulse |
| unplug_evt | output | 1 | Disconnect pulse |

## Verification
A wrong timer value does not show at the ports until the timer should reach, or has reached, a timeout. Only the timing of a pulse reveals such an error, possibly hundreds of ticks after it arose. For this reason the directed cases first drive each timer to a known partial level, then make it drain, then let it climb to the limit. An error of even one step in the rise or fall rate, or in the saturation points, then moves the pulse by at least one tick. Randomly mixed flag patterns compare every tick against a bench model. Scrambled flags on clocks without a tick expose any update that does not wait for the tick strobe.

// File: rtl/port_fault_timers.sv
module port_fault_timers #(
  parameter int OC_LIMIT_MS   = 60,
  parameter int OC_DRAIN_DIV  = 16,
  parameter int HL_LIMIT_MS   = 15,
  parameter int DC_LIMIT_MS   = 350,
  parameter int DC_DRAIN_MUL  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_1ms,
  input  logic port_on,
  input  logic big_load,
  input  logic over_trip,
  input  logic at_limit,
  input  logic under_hold,
  output logic ovl_fault,
  output logic unplug_evt
);
  localparam int OC_FULL = OC_LIMIT_MS * OC_DRAIN_DIV;
  localparam int OC_W = $clog2(OC_FULL + 1);
  localparam int HL_W = $clog2(HL_LIMIT_MS + 1);
  localparam int DC_W = $clog2(DC_LIMIT_MS + 1);
  localparam logic [OC_W-1:0] OC_TOP  = OC_W'(OC_FULL);
  localparam logic [OC_W-1:0] OC_STEP = OC_W'(OC_DRAIN_DIV);
  localparam logic [OC_W-1:0] OC_ONE  = OC_W'(1);
  localparam logic [HL_W-1:0] HL_TOP  = HL_W'(HL_LIMIT_MS);
  localparam logic [HL_W-1:0] HL_ONE  = HL_W'(1);
  localparam logic [DC_W-1:0] DC_TOP  = DC_W'(DC_LIMIT_MS);
  localparam logic [DC_W-1:0] DC_ONE  = DC_W'(1);
  localparam logic [DC_W-1:0] DC_DROP = DC_W'(DC_DRAIN_MUL);

  logic [OC_W-1:0] oc_acc, oc_nxt;
  logic [HL_W-1:0] hl_cnt, hl_nxt;
  logic [DC_W-1:0] dc_acc, dc_nxt;
  logic            step, oc_hit, hl_hit, dc_hit;

  assign step = tick_1ms & port_on;

  always_comb begin
    if (over_trip)
      oc_nxt = (oc_acc >= OC_TOP - OC_STEP) ? OC_TOP : oc_acc + OC_STEP;
    else
      oc_nxt = (oc_acc == '0) ? '0 : oc_acc - OC_ONE;
  end

  assign hl_nxt = (big_load & at_limit) ? ((hl_cnt == HL_TOP) ? HL_TOP : hl_cnt + HL_ONE) : '0;

  always_comb begin
    if (under_hold)
      dc_nxt = (dc_acc == DC_TOP) ? DC_TOP : dc_acc + DC_ONE;
    else
      dc_nxt = (dc_acc <= DC_DROP) ? '0 : dc_acc - DC_DROP;
  end

  assign oc_hit = step & (oc_nxt == OC_TOP) & (oc_acc != OC_TOP);
  assign hl_hit = step & (hl_nxt == HL_TOP) & (hl_cnt != HL_TOP);
  assign dc_hit = step & (dc_nxt == DC_TOP) & (dc_acc != DC_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_acc     <= '0;
      hl_cnt     <= '0;
      dc_acc     <= '0;
      ovl_fault  <= 1'b0;
      unplug_evt <= 1'b0;
    end else begin
      ovl_fault  <= oc_hit | hl_hit;
      unplug_evt <= dc_hit & ~(oc_hit | hl_hit);
      if (!port_on) begin
        oc_acc <= '0;
        hl_cnt <= '0;
        dc_acc <= '0;
      end else if (tick_1ms) begin
        oc_acc <= oc_nxt;
        hl_cnt <= hl_nxt;
        dc_acc <= dc_nxt;
      end
    end
  end

  AST_OC_BOUND: assert property (@(posedge clk) disable iff (!rst_n) oc_acc <= OC_TOP); // R2
  AST_DC_BOUND: assert property (@(posedge clk) disable iff (!rst_n) dc_acc <= DC_TOP); // R5
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !port_on |=> (oc_acc == '0 && hl_cnt == '0 && dc_acc == '0)); // R7
  AST_QUIET_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
    !port_on |=> (!ovl_fault && !unplug_evt)); // R7
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (port_on && !tick_1ms) |=> ($stable(oc_acc) && $stable(hl_cnt) && $stable(dc_acc))); // R8
  AST_OC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) ovl_fault |=> !ovl_fault); // R8
  AST_DC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) unplug_evt |=> !unplug_evt); // R8
  AST_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n) !(ovl_fault && unplug_evt)); // R9
  AST_HL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1ms && !at_limit) |=> hl_cnt == '0); // R4
endmodule

// File: tb/tb_port_fault_timers.sv
module tb_port_fault_timers;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_1ms = 0, port_on = 0, big_load = 0, over_trip = 0, at_limit = 0, under_hold = 0;
  logic ovl_fault, unplug_evt;
  int checks = 0, errors = 0, cycles = 0;
  int m_oc = 0, m_hl = 0, m_dc = 0;

  always #4 clk = ~clk;

  port_fault_timers dut (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .port_on(port_on), .big_load(big_load),
    .over_trip(over_trip), .at_limit(at_limit), .under_hold(under_hold),
    .ovl_fault(ovl_fault), .unplug_evt(unplug_evt));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_tick(input bit p, input bit c4, input bit ov, input bit lim, input bit und, input string req);
    bit e_oc, e_dc;
    int n_oc, n_hl, n_dc;
    @(negedge clk);
    port_on = p; big_load = c4; over_trip = ov; at_limit = lim; under_hold = und; tick_1ms = 1;
    if (!p) begin
      n_oc = 0; n_hl = 0; n_dc = 0; e_oc = 0; e_dc = 0;
    end else begin
      n_oc = ov ? ((m_oc + 16 > 960) ? 960 : m_oc + 16) : ((m_oc == 0) ? 0 : m_oc - 1);
      n_hl = (c4 && lim) ? ((m_hl == 15) ? 15 : m_hl + 1) : 0;
      n_dc = und ? ((m_dc == 350) ? 350 : m_dc + 1) : ((m_dc <= 10) ? 0 : m_dc - 10);
      e_oc = (n_oc == 960 && m_oc != 960) || (n_hl == 15 && m_hl != 15);
      e_dc = (n_dc == 350 && m_dc != 350) && !e_oc;
    end
    m_oc = n_oc; m_hl = n_hl; m_dc = n_dc;
    @(negedge clk);
    tick_1ms = 0;
    chk({req, " overcurrent pulse"}, int'(ovl_fault), int'(e_oc));
    chk({req, " disconnect pulse"}, int'(unplug_evt), int'(e_dc));
    big_load = 1'($urandom); over_trip = 1'($urandom); at_limit = 1'($urandom); under_hold = 1'($urandom);
    @(negedge clk);
    chk("R8 pulse width", int'(ovl_fault | unplug_evt), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 190000 cycles", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int seed;
    seed = 32'h1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk("R1 reset fault", int'(ovl_fault), 0);
    chk("R1 reset disc", int'(unplug_evt), 0);
    rst_n = 1;
    @(negedge clk);
    port_on = 1;
    repeat (3) @(negedge clk);
    chk("R1 idle after release", int'(ovl_fault | unplug_evt), 0);
    // R2: 60 ticks of overcurrent from zero
    for (int i = 0; i < 60; i++) do_tick(1, 0, 1, 0, 0, "R2");
    do_tick(0, 0, 0, 0, 0, "R7");
    // R3: partial rise, 1/16 drain, then rise to limit
    for (int i = 0; i < 30; i++) do_tick(1, 0, 1, 0, 0, "R3");
    for (int i = 0; i < 32; i++) do_tick(1, 0, 0, 0, 0, "R3");
    for (int i = 0; i < 32; i++) do_tick(1, 0, 1, 0, 0, "R3");
    do_tick(0, 0, 0, 0, 0, "R7");
    // R4: class-4 hard limit, break in the run, non-class-4 ignored
    for (int i = 0; i < 14; i++) do_tick(1, 1, 0, 1, 0, "R4");
    do_tick(1, 1, 0, 0, 0, "R4");
    for (int i = 0; i < 15; i++) do_tick(1, 1, 0, 1, 0, "R4");
    do_tick(0, 0, 0, 0, 0, "R7");
    for (int i = 0; i < 30; i++) do_tick(1, 0, 0, 1, 0, "R4");
    do_tick(0, 0, 0, 0, 0, "R7");
    // R5/R6: disconnect rise, fast drain, rise again
    for (int i = 0; i < 340; i++) do_tick(1, 0, 0, 0, 1, "R5");
    for (int i = 0; i < 3; i++) do_tick(1, 0, 0, 0, 0, "R6");
    for (int i = 0; i < 45; i++) do_tick(1, 0, 0, 0, 1, "R6");
    do_tick(0, 0, 0, 0, 0, "R7");
    // R9: both timers expire on the same tick
    for (int i = 0; i < 290; i++) do_tick(1, 0, 0, 0, 1, "R9");
    for (int i = 0; i < 60; i++) do_tick(1, 0, 1, 0, 1, "R9");
    // R7: unpowered with active flags, then restart from zero
    for (int i = 0; i < 20; i++) do_tick(0, 1, 1, 1, 1, "R7");
    for (int i = 0; i < 60; i++) do_tick(1, 0, 1, 0, 0, "R7");
    do_tick(0, 0, 0, 0, 0, "R7");
    // Random segments
    for (int s = 0; s < 60; s++) begin
      int len, p_ov, p_un, p_lim;
      bit c4, pw;
      len = 1 + int'($urandom % 250);
      p_ov = int'($urandom % 100); p_un = int'($urandom % 100); p_lim = int'($urandom % 100);
      c4 = 1'($urandom); pw = ($urandom % 10) != 0;
      for (int i = 0; i < len; i++)
        do_tick(pw, c4, int'($urandom % 100) < p_ov, int'($urandom % 100) < p_lim,
                int'($urandom % 100) < p_un, "R2-random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule